// File: doc/BRIEF.md
# Ethernet Destination Address Filter

The filter decides whether a received Ethernet frame is kept, based only on its 6-byte destination address. The receive path pulses `frameStart` at the start of a frame. It then presents the destination bytes one per clock on `byteData` with `byteValid`, first received byte first. The cycle after the sixth byte is taken, the filter raises `decValid` for one cycle, and `decAccept` gives the verdict in that same cycle.

Three mode inputs choose the acceptance policy:
- **Promiscuous mode** accepts everything.
- **Broadcast** gates the all-ones address.
- **Multicast** gates group addresses. A group address must also hit a 64-bit hash mask, indexed by a bitwise CRC-32 taken over the address.

All other addresses must equal the programmed station address. A small byte-wide write port loads the station address and the hash mask.

Top module: `dest_addr_filter`

## Requirements
- R1: When `promiscEn` is 1 in the cycle the sixth byte is taken, the frame is accepted whatever its address.
- R2: With promiscuous mode off, an address of six 0xFF bytes is accepted if and only if `bcastEn` is 1.
- R3: With promiscuous mode off, an address whose first byte has bit 0 set, and which is not all ones, is rejected when `mcastEn` is 0, whatever the mask holds.
- R4: With `mcastEn` set, such a group address is accepted only if the selected mask bit is 1. The hash is computed as follows:
  - The CRC starts at 0xFFFFFFFF.
  - It takes the six bytes in order, each byte least significant bit first.
  - Per bit, carry = CRC[31] XOR the input bit, and the CRC shifts left by one.
  - If carry is 1, the CRC is XORed with 0x04C11DB6 and then bit 0 is set.
  - The index is CRC[31:26] after the 48th bit. It selects mask byte index[5:3], bit index[2:0], that is mask bit `index` of the 64-bit mask.
- R5: Any other address is accepted only when all six bytes equal the station address, where station byte k is compared with received byte k. A single differing byte rejects the frame.
- R6: A write with `cfgWe` high stores `cfgData` into station byte k when `cfgAddr` is k (0 to 5), and into mask byte k when `cfgAddr` is 8+k (0 to 7). Mask byte k holds mask bits 8k+7 down to 8k.
- R7: `decValid` is a single-cycle pulse in the cycle after the clock edge that takes the sixth byte. `decAccept` is 0 whenever `decValid` is 0.
- R8: Bytes offered after the sixth byte of a frame, or after reset before any `frameStart`, are ignored and produce no decision.
- R9: `frameStart` discards any partly received address and restarts the count. A byte offered in the same cycle as `frameStart` is ignored.
- R10: After reset, `decValid` and `decAccept` are 0, and the station address and mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Restart strobe for a new destination address |
| byteValid | input | 1 | `byteData` carries a destination byte |
| byteData | input | 8 | Destination address byte, first received first |
| promiscEn | input | 1 | Accept every frame |
| bcastEn | input | 1 | Accept the all-ones address |
| mcastEn | input | 1 | Allow group addresses through the hash mask |
| cfgWe | input | 1 | Write strobe for station and mask bytes |
| cfgAddr | input | 4 | Station byte 0-5, mask byte 8-15 |
| cfgData | input | 8 | Write data |
| decValid | output | 1 | One-cycle decision strobe |
| decAccept | output | 1 | Frame accepted, qualified by `decValid` |

## Verification
Unicast addresses are tried against the programmed station address twice: once equal, and once differing only in the first or only in the last byte. This separates a full six-byte compare from a partial one.

Group addresses are run against three masks:
- an empty mask;
- a mask holding only the bit predicted by a bench model of the hash;
- a full mask missing only that bit.

Together these pin the CRC index and the mask bit ordering. Broadcast and promiscuous runs toggle each mode bit against an address that would otherwise fail. This shows which rule takes priority. Restart and overrun patterns confirm that stray bytes neither shift the decision nor create an extra one.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] HASH_POLY = 32'h04C1_1DB6;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic clr;    // restart: seed CRC, arm compares
    logic take;   // a destination byte is consumed this cycle
    logic first;  // consumed byte is the first one
    logic last;   // consumed byte completes the address
  } filtCtrl_t;

  // Advance the hash by one byte, least significant bit first
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [7:0] din);
    logic [CRC_W-1:0] c;
    logic carry;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      carry = c[CRC_W-1] ^ din[i];
      c = c << 1;
      if (carry) c = (c ^ HASH_POLY) | 32'h1;
    end
    return c;
  endfunction

endpackage

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import addr_filter_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int IDX_W  = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             byteValid,
  output filtCtrl_t        ctrl,
  output logic [IDX_W-1:0] byteIdx
);

  localparam logic [IDX_W-1:0] IDLE_CNT = IDX_W'(NBYTES);
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(NBYTES - 1);

  logic [IDX_W-1:0] byteCnt;

  always_comb begin
    ctrl.clr   = frameStart;
    ctrl.take  = byteValid && !frameStart && (byteCnt != IDLE_CNT);
    ctrl.first = ctrl.take && (byteCnt == '0);
    ctrl.last  = ctrl.take && (byteCnt == LAST_CNT);
  end

  assign byteIdx = byteCnt;

  // Idle at the full count until a frame start arms the counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          byteCnt <= IDLE_CNT;
    else if (ctrl.clr)  byteCnt <= '0;
    else if (ctrl.take) byteCnt <= byteCnt + 1'b1;
  end

endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import addr_filter_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int DW     = 8,
  parameter int HASHW  = 6,
  parameter int IDX_W  = $clog2(NBYTES + 1),
  parameter int CFG_AW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtCtrl_t         ctrl,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [DW-1:0]     byteData,
  input  logic              promiscEn,
  input  logic              bcastEn,
  input  logic              mcastEn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DW-1:0]     cfgData,
  output logic              decValid,
  output logic              decAccept
);

  localparam int MASK_BITS  = 2 ** HASHW;
  localparam int MASK_BYTES = MASK_BITS / DW;
  localparam int MASK_BASE  = 2 ** $clog2(NBYTES);

  logic [DW-1:0]        staReg [NBYTES];
  logic [MASK_BITS-1:0] maskReg;
  logic [CRC_W-1:0]     crcReg, crcNext;
  logic                 matchReg, matchNext;
  logic                 onesReg, onesNext;
  logic                 groupReg, groupNext;
  logic [HASHW-1:0]     hashIdx;
  logic                 hashHit, acceptNow;

  // Configuration storage: station bytes and mask bytes
  for (genvar k = 0; k < NBYTES; k++) begin : g_sta
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     staReg[k] <= '0;
      else if (cfgWe && cfgAddr == CFG_AW'(k))       staReg[k] <= cfgData;
    end
  end

  for (genvar k = 0; k < MASK_BYTES; k++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          maskReg[k*DW +: DW] <= '0;
      else if (cfgWe && cfgAddr == CFG_AW'(MASK_BASE + k)) maskReg[k*DW +: DW] <= cfgData;
    end
  end

  // Per-byte evaluation of the address classes
  always_comb begin
    crcNext   = crcByte(crcReg, byteData);
    matchNext = matchReg && (byteData == staReg[byteIdx]);
    onesNext  = onesReg && (&byteData);
    groupNext = ctrl.first ? byteData[0] : groupReg;
    hashIdx   = crcNext[CRC_W-1 -: HASHW];
    hashHit   = maskReg[hashIdx];
    if (promiscEn)      acceptNow = 1'b1;
    else if (onesNext)  acceptNow = bcastEn;
    else if (groupNext) acceptNow = mcastEn && hashHit;
    else                acceptNow = matchNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= CRC_SEED;
      matchReg <= 1'b1;
      onesReg  <= 1'b1;
      groupReg <= 1'b0;
    end else if (ctrl.clr) begin
      crcReg   <= CRC_SEED;
      matchReg <= 1'b1;
      onesReg  <= 1'b1;
      groupReg <= 1'b0;
    end else if (ctrl.take) begin
      crcReg   <= crcNext;
      matchReg <= matchNext;
      onesReg  <= onesNext;
      groupReg <= groupNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
    end else begin
      decValid  <= ctrl.last;
      decAccept <= ctrl.last && acceptNow;
    end
  end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import addr_filter_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int DW     = 8,
  parameter int HASHW  = 6,
  localparam int IDX_W  = $clog2(NBYTES + 1),
  localparam int CFG_AW = $clog2(2 ** $clog2(NBYTES) + (2 ** HASHW) / DW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [DW-1:0]     byteData,
  input  logic              promiscEn,
  input  logic              bcastEn,
  input  logic              mcastEn,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DW-1:0]     cfgData,
  output logic              decValid,
  output logic              decAccept
);

  filtCtrl_t        ctrl;
  logic [IDX_W-1:0] byteIdx;

  addr_filter_ctrl #(.NBYTES(NBYTES), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .ctrl(ctrl), .byteIdx(byteIdx)
  );

  addr_filter_dp #(.NBYTES(NBYTES), .DW(DW), .HASHW(HASHW), .IDX_W(IDX_W),
                   .CFG_AW(CFG_AW)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteIdx(byteIdx), .byteData(byteData),
    .promiscEn(promiscEn), .bcastEn(bcastEn), .mcastEn(mcastEn),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .decValid(decValid), .decAccept(decAccept)
  );

endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic byteValid,
  input logic promiscEn,
  input logic decValid,
  input logic decAccept
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid); // R7

  AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    decAccept |-> decValid); // R7

  AST_PROMISC_ACCEPTS: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(promiscEn)) |-> decAccept); // R1

  AST_DECISION_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> $past(byteValid && !frameStart)); // R8

  AST_RESTART_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !decValid); // R9

endmodule

bind dest_addr_filter addr_filter_chk chk_i (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
  .promiscEn(promiscEn), .decValid(decValid), .decAccept(decAccept)
);

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic       promiscEn = 1'b0, bcastEn = 1'b0, mcastEn = 1'b0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       decValid, decAccept;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;

  always #2 clk = ~clk;

  dest_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .promiscEn(promiscEn), .bcastEn(bcastEn),
    .mcastEn(mcastEn), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .decValid(decValid), .decAccept(decAccept)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Bench model of the hash index (R4)
  function automatic logic [5:0] hashOf(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0] b;
    logic carry;
    for (int i = 0; i < 6; i++) begin
      b = da[47 - 8*i -: 8];
      for (int j = 0; j < 8; j++) begin
        carry = c[31] ^ b[0];
        c = c << 1;
        b = b >> 1;
        if (carry) c = (c ^ 32'h04C11DB6) | 32'h1;
      end
    end
    return c[31:26];
  endfunction

  task automatic cfgWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic writeStation(input logic [47:0] s);
    for (int k = 0; k < 6; k++) cfgWrite(4'(k), s[47 - 8*k -: 8]);
  endtask

  task automatic writeMask(input logic [63:0] m);
    for (int k = 0; k < 8; k++) cfgWrite(4'(8 + k), m[8*k +: 8]);
  endtask

  task automatic setModes(input logic p, input logic b, input logic m);
    @(negedge clk); promiscEn = p; bcastEn = b; mcastEn = m;
  endtask

  // Send one address; sample in the cycle after the sixth byte
  task automatic sendFrame(input logic [47:0] da, output logic v, output logic acc);
    @(negedge clk); frameStart = 1'b1; byteValid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); frameStart = 1'b0; byteValid = 1'b1; byteData = da[47 - 8*k -: 8];
    end
    @(negedge clk); byteValid = 1'b0;
    v = decValid; acc = decAccept;
  endtask

  task automatic expectFrame(input string req, input logic [47:0] da, input logic expAcc);
    logic v, a;
    sendFrame(da, v, a);
    chk(req, {31'd0, v}, 32'd1);
    chk(req, {31'd0, a}, {31'd0, expAcc});
  endtask

  task automatic testReset();
    chk("R10 valid after reset", {31'd0, decValid}, 32'd0);
    chk("R10 accept after reset", {31'd0, decAccept}, 32'd0);
    // R8: bytes without a frame start give no decision
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); byteValid = 1'b1; byteData = 8'(k);
      chk("R8 no decision before start", {31'd0, decValid}, 32'd0);
    end
    @(negedge clk); byteValid = 1'b0;
    chk("R8 no decision before start", {31'd0, decValid}, 32'd0);
    // R10: station resets to zero, so an all-zero address matches
    expectFrame("R10 zero station", 48'h0, 1'b1);
  endtask

  task automatic testUnicast();
    writeStation(STATION);
    setModes(0, 0, 0);
    expectFrame("R5 exact match", STATION, 1'b1);
    expectFrame("R5 last byte differs", STATION ^ 48'h1, 1'b0);
    expectFrame("R5 first byte differs", STATION ^ 48'h04_00_00_00_00_00, 1'b0);
    expectFrame("R5 R6 old station gone", 48'h0, 1'b0);
  endtask

  task automatic testPulse();
    logic v, a;
    sendFrame(STATION, v, a);
    chk("R7 pulse present", {31'd0, v}, 32'd1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'd0, decValid}, 32'd0);
    chk("R7 accept qualified", {31'd0, decAccept}, 32'd0);
  endtask

  task automatic testOverrun();
    logic v, a;
    sendFrame(STATION, v, a);
    chk("R8 first decision", {31'd0, v}, 32'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); byteValid = 1'b1; byteData = STATION[47 - 8*(k % 6) -: 8];
      chk("R8 extra bytes ignored", {31'd0, decValid}, 32'd0);
    end
    @(negedge clk); byteValid = 1'b0;
    chk("R8 extra bytes ignored", {31'd0, decValid}, 32'd0);
  endtask

  task automatic testRestart();
    @(negedge clk); frameStart = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); frameStart = 1'b0; byteValid = 1'b1; byteData = 8'hAA;
    end
    // Restart with a byte offered in the same cycle: byte must be dropped
    @(negedge clk); frameStart = 1'b1; byteValid = 1'b1; byteData = 8'hAA;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); frameStart = 1'b0; byteValid = 1'b1;
      byteData = STATION[47 - 8*k -: 8];
      chk("R9 no early decision", {31'd0, decValid}, 32'd0);
    end
    @(negedge clk); byteValid = 1'b0;
    chk("R9 decision after restart", {31'd0, decValid}, 32'd1);
    chk("R9 restart clears mismatch", {31'd0, decAccept}, 32'd1);
  endtask

  task automatic testBroadcast();
    setModes(0, 0, 1);
    writeMask(64'hFFFF_FFFF_FFFF_FFFF);
    expectFrame("R2 broadcast off", 48'hFFFF_FFFF_FFFF, 1'b0);
    setModes(0, 1, 0);
    expectFrame("R2 broadcast on", 48'hFFFF_FFFF_FFFF, 1'b1);
  endtask

  task automatic testMulticast(input logic [47:0] grp);
    logic [5:0] idx = hashOf(grp);
    setModes(0, 0, 0);
    writeMask(64'hFFFF_FFFF_FFFF_FFFF);
    expectFrame("R3 group disabled", grp, 1'b0);
    setModes(0, 0, 1);
    writeMask(64'h0);
    expectFrame("R4 empty mask", grp, 1'b0);
    writeMask(64'h1 << idx);
    expectFrame("R4 selected bit set", grp, 1'b1);
    writeMask(~(64'h1 << idx));
    expectFrame("R4 selected bit clear", grp, 1'b0);
  endtask

  task automatic testPromisc();
    writeMask(64'h0);
    setModes(1, 0, 0);
    expectFrame("R1 unicast mismatch", 48'h00_DE_AD_BE_EF_00, 1'b1);
    expectFrame("R1 group empty mask", 48'h01_00_5E_7F_00_01, 1'b1);
    expectFrame("R1 broadcast", 48'hFFFF_FFFF_FFFF, 1'b1);
    setModes(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnicast();
    testPulse();
    testOverrun();
    testRestart();
    testBroadcast();
    testMulticast(48'h01_00_5E_00_00_01);
    testMulticast(48'h33_33_00_00_00_FB);
    testPromisc();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule